// File: doc/BRIEF.md
# Masked bit-manipulation ALU unit

This execution unit carries out a single masked bit-manipulation operation per issue. A mask is taken either from the second source operand or, when the second register specifier was zero, set to all ones. Two working values are derived from the first source operand. The first is the operand itself or its complement. The second is one of four increment, decrement or negation forms. Both are confined to the mask and combined with OR, AND or XOR. The combined value is confined to the mask again, and can optionally have the first operand's bits outside the mask merged back in.

Choosing the sub-mode and the operator well yields the usual mask idioms on the masked field. Examples are isolating the lowest set bit (`a & -a`), clearing it (`a & (a-1)`), and building a mask up to it (`a ^ (a-1)`). Trailing-ones forms come from the increment variants. The unit accepts one operation on a `valid_in` pulse and presents a registered result one cycle later. On request it also returns a three-way sign/zero condition field for the result.

Top module: `bitmask_alu`

## Requirements
- R1: When `rb_zero` is 1 the mask is all ones across XLEN bits; otherwise the mask equals `rb`.
- R2: The first working value is `ra & mask` when `inv` is 0, and `~ra & mask` when `inv` is 1.
- R3: `a2_sel` picks the second working value before masking: 0 gives `~ra + 1`, 1 gives `ra - 1`, 2 gives `ra + 1`, 3 gives `~(ra + 1)`. The chosen value is then ANDed with the mask.
- R4: `op_sel` combines the two masked values: 0 is OR, 1 is AND, 2 is XOR. The combined value is ANDed with the mask.
- R5: `op_sel` = 3 produces an all-zero combined value. It also raises `illegal_out` for exactly the one cycle in which `valid_out` presents that result.
- R6: With `keep` at 0, every result bit outside the mask is 0.
- R7: With `keep` at 1, the result is the masked combined value ORed with `ra & ~mask`, so `ra` passes through unchanged outside the mask.
- R8: `valid_out` is 1 exactly in the cycle after a cycle with `valid_in` at 1. A synchronous active-high `rst` clears `valid_out` and `illegal_out`.
- R9: With `rec` at 1, `cond_out` is {negative, positive, zero} of the result read as a signed number (bit 2 negative, bit 1 positive, bit 0 zero), with exactly one bit set. With `rec` at 0, `cond_out` is 0.
- R10: All increment, decrement and negation in R3 wrap modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation issue strobe |
| ra | input | XLEN | First source operand |
| rb | input | XLEN | Mask operand |
| rb_zero | input | 1 | Second register specifier was zero: use an all-ones mask |
| inv | input | 1 | Complement the first working value |
| a2_sel | input | 2 | Second working value form |
| op_sel | input | 2 | Combining operator |
| keep | input | 1 | Merge unmasked `ra` bits into the result |
| rec | input | 1 | Produce the condition field |
| valid_out | output | 1 | Result valid |
| res_out | output | XLEN | Registered result |
| cond_out | output | 3 | Condition field {neg, pos, zero} |
| illegal_out | output | 1 | Operator select 3 was used |

## Verification
The bench sweeps every combination of invert, sub-mode, operator, merge, mask source and record flag. It runs each combination over the operands 0, all ones, the most negative value and random data. A unit that wraps wrongly would give a wrong `ra + 1` for all ones or a wrong `ra - 1` for zero. A unit that skips the second masking would leak carry bits above a narrow mask. A merge that reuses the complemented operand would restore inverted bits. The most negative value probes the condition field, where an unsigned compare would report it as positive. Operator select 3 checks that the result is cleared and that the illegal flag pulses only alongside its result.

// File: rtl/bitmask_alu.sv
module bitmask_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_in,
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  input  logic            rb_zero,
  input  logic            inv,
  input  logic [1:0]      a2_sel,
  input  logic [1:0]      op_sel,
  input  logic            keep,
  input  logic            rec,
  output logic            valid_out,
  output logic [XLEN-1:0] res_out,
  output logic [2:0]      cond_out,
  output logic            illegal_out
);

  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};
  localparam logic [XLEN-1:0] ONE  = XLEN'(1);

  logic [XLEN-1:0] mask, a1, a2_raw, a2, comb, res;
  logic [2:0]      cond;
  logic            bad_op;

  assign mask = rb_zero ? ONES : rb;
  assign a1   = (inv ? ~ra : ra) & mask;

  always_comb begin
    unique case (a2_sel)
      2'd0:    a2_raw = ~ra + ONE;
      2'd1:    a2_raw = ra - ONE;
      2'd2:    a2_raw = ra + ONE;
      default: a2_raw = ~(ra + ONE);
    endcase
  end

  assign a2     = a2_raw & mask;
  assign bad_op = (op_sel == 2'd3);

  always_comb begin
    unique case (op_sel)
      2'd0:    comb = a1 | a2;
      2'd1:    comb = a1 & a2;
      2'd2:    comb = a1 ^ a2;
      default: comb = '0;
    endcase
  end

  assign res = (comb & mask) | (keep ? (ra & ~mask) : '0);

  always_comb begin
    cond = 3'b000;
    if (rec) begin
      if (res[XLEN-1])   cond = 3'b100;
      else if (res != 0) cond = 3'b010;
      else               cond = 3'b001;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out   <= 1'b0;
      illegal_out <= 1'b0;
    end else begin
      valid_out   <= valid_in;
      illegal_out <= valid_in && bad_op;
    end
    if (valid_in) begin
      res_out  <= res;
      cond_out <= cond;
    end
  end

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out && !illegal_out);
  p_illegal_zero_r5: assert property (@(posedge clk) disable iff (rst)
    illegal_out |-> valid_out && ((res_out & ~$past(keep ? ~mask : '0)) == '0));
  p_outside_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !keep) |=> (res_out & ~$past(mask)) == '0);
  p_outside_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_in && keep) |=> ((res_out ^ $past(ra)) & ~$past(mask)) == '0);
  p_cond_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $onehot0(cond_out));
  p_cond_present_r9: assert property (@(posedge clk) disable iff (rst)
    (valid_in && rec) |=> $countones(cond_out) == 1);

endmodule

// File: tb/tb_bitmask_alu.sv
module tb_bitmask_alu;
  localparam int XLEN = 64;
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};
  localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

  logic            clk = 0, rst = 1, valid_in = 0;
  logic [XLEN-1:0] ra = 0, rb = 0;
  logic            rb_zero = 0, inv = 0, keep = 0, rec = 0;
  logic [1:0]      a2_sel = 0, op_sel = 0;
  logic            valid_out, illegal_out;
  logic [XLEN-1:0] res_out;
  logic [2:0]      cond_out;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bitmask_alu #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .ra(ra), .rb(rb),
    .rb_zero(rb_zero), .inv(inv), .a2_sel(a2_sel), .op_sel(op_sel),
    .keep(keep), .rec(rec), .valid_out(valid_out), .res_out(res_out),
    .cond_out(cond_out), .illegal_out(illegal_out));

  function automatic logic [XLEN-1:0] ref_res(
      logic [XLEN-1:0] x, logic [XLEN-1:0] y, bit z, bit iv,
      logic [1:0] s, logic [1:0] o, bit k);
    logic [XLEN-1:0] m, p, q, c;
    m = z ? ONES : y;
    p = iv ? ~x : x;
    case (s)
      2'd0: q = (~x) + 1;
      2'd1: q = x - 1;
      2'd2: q = x + 1;
      default: q = ~(x + 1);
    endcase
    p = p & m;
    q = q & m;
    case (o)
      2'd0: c = p | q;
      2'd1: c = p & q;
      2'd2: c = p ^ q;
      default: c = '0;
    endcase
    c = c & m;
    if (k) c = c | (x & ~m);
    return c;
  endfunction

  function automatic logic [2:0] ref_cond(logic [XLEN-1:0] r, bit rc);
    if (!rc) return 3'b000;
    if ($signed(r) < 0) return 3'b100;
    if (r != 0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(bit ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [XLEN-1:0] x, logic [XLEN-1:0] y, bit z, bit iv,
                       logic [1:0] s, logic [1:0] o, bit k, bit rc);
    logic [XLEN-1:0] er;
    logic [2:0] ec;
    er = ref_res(x, y, z, iv, s, o, k);
    ec = ref_cond(er, rc);
    ra = x; rb = y; rb_zero = z; inv = iv; a2_sel = s; op_sel = o;
    keep = k; rec = rc; valid_in = 1;
    @(negedge clk);
    valid_in = 0;
    chk(valid_out === 1'b1, "R8 valid_out after issue", XLEN'(valid_out), 1);
    chk(res_out === er, "R1/R2/R3/R4/R6/R7/R10 result", res_out, er);
    chk(cond_out === ec, "R9 cond", XLEN'(cond_out), XLEN'(ec));
    chk(illegal_out === (o == 2'd3), "R5 illegal flag", XLEN'(illegal_out), XLEN'(o == 2'd3));
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] ops [4];
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(valid_out === 1'b0, "R8 reset valid_out", XLEN'(valid_out), 0);
    chk(illegal_out === 1'b0, "R8 reset illegal_out", XLEN'(illegal_out), 0);
    rst = 0;
    @(negedge clk);
    chk(valid_out === 1'b0, "R8 idle valid_out", XLEN'(valid_out), 0);

    // R10 directed wrap cases
    apply(ONES, 0, 1, 0, 2'd2, 2'd0, 0, 1);
    chk(res_out === ONES, "R10 ones+1 OR", res_out, ONES);
    apply('0, 0, 1, 0, 2'd1, 2'd2, 0, 1);
    chk(res_out === ONES, "R10 zero-1 XOR", res_out, ONES);
    // lowest set bit isolate with narrow mask and keep (R7)
    apply(64'hF0F0_0000_0000_0068, 64'h0000_0000_0000_00FF, 0, 0, 2'd0, 2'd1, 1, 1);
    chk(res_out === 64'hF0F0_0000_0000_0008, "R7 isolate low bit keep", res_out, 64'hF0F0_0000_0000_0008);
    @(negedge clk);
    chk(valid_out === 1'b0, "R8 single-cycle valid", XLEN'(valid_out), 0);
    chk(illegal_out === 1'b0, "R5 illegal drops", XLEN'(illegal_out), 0);

    for (int rz = 0; rz < 2; rz++)
      for (int iv = 0; iv < 2; iv++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 4; o++)
            for (int k = 0; k < 2; k++)
              for (int rc = 0; rc < 2; rc++) begin
                ops[0] = '0;
                ops[1] = ONES;
                ops[2] = MINV;
                ops[3] = {$urandom, $urandom};
                for (int v = 0; v < 4; v++)
                  apply(ops[v], {$urandom, $urandom} & {$urandom, $urandom},
                        rz[0], iv[0], s[1:0], o[1:0], k[0], rc[0]);
                apply({$urandom, $urandom}, {$urandom, $urandom}, rz[0], iv[0],
                      s[1:0], o[1:0], k[0], rc[0]);
              end

    repeat (2) @(negedge clk);
    chk(valid_out === 1'b0, "R8 final idle", XLEN'(valid_out), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule